// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block sits next to a UART receiver and decides when an incoming message has ended. It measures how long the line has stayed idle since the last received character. Idle time is counted in whole character periods, and the length of one period in bit times follows from the programmed frame format. When a programmable number of idle characters pass with no new data, the block raises a one-cycle timeout pulse so the receive buffer can be closed. It also sets a sticky interrupt flag, which a mask can suppress.

Counting is armed only after a data character arrives. A new character restarts the count. A bit time with the line low counts as a start bit and abandons the idle character in progress. A limit of zero turns the whole feature off. After a timeout the detector stays quiet until the next character. The running count is a down-counter that is loaded from the limit whenever a character is received, so software never has to set it up. Bit sampling and buffer handling belong to the neighbouring receiver.

Top module: `uart_idle_timeout`

## Requirements
- R1: After a synchronous active-low reset, `timeout_pulse`, `irq_flag` and `idle_count` are all 0 and the detector is disarmed.
- R2: One idle character lasts 1 + D + P + S bit ticks. D is `data_len` read as a binary number and clamped into 5..9. P is 1 when `parity_en` is 1. S is 2 when `two_stop` is 1 and 1 otherwise.
- R3: In the cycle after a `char_strobe`, `idle_count` equals `max_idle`. It then drops by one for each completed idle character.
- R4: When the `max_idle`-th idle character completes, `timeout_pulse` is high for exactly one cycle. That cycle directly follows the clock edge that sampled the final high bit tick.
- R5: A bit tick sampled with `rx_line` low discards the idle character in progress. The next full character length of high ticks must then pass before the count drops.
- R6: A `char_strobe` while armed restarts the count from `max_idle` and discards the partial idle character.
- R7: With `max_idle` equal to 0 at the strobe, the detector stays disarmed, `idle_count` stays 0 and no timeout occurs.
- R8: After a timeout the detector is disarmed with `idle_count` 0, and it produces no timeout, however long the line stays idle, until the next `char_strobe`.
- R9: A timeout with `irq_mask_en` high sets `irq_flag`, which then holds until `irq_clear` is high for one cycle.
- R10: A timeout with `irq_mask_en` low still pulses `timeout_pulse` but leaves `irq_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per bit time |
| rx_line | input | 1 | Receive line level sampled on `bit_tick` |
| char_strobe | input | 1 | One-cycle pulse per received data character |
| data_len | input | 4 | Data bits per character (5 to 9) |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| max_idle | input | 16 | Idle characters allowed before a timeout; 0 disables |
| irq_mask_en | input | 1 | Lets a timeout set the interrupt flag |
| irq_clear | input | 1 | Write-one-to-clear for the interrupt flag |
| timeout_pulse | output | 1 | One-cycle timeout indication |
| irq_flag | output | 1 | Sticky interrupt request |
| idle_count | output | 16 | Remaining idle characters before a timeout |

## Verification
The detector is driven with several kinds of idle stretch, and a scoreboard predicts the exact cycle of each timeout:
- Unbroken high ticks over three frame formats (10, 9 and 13 bits), which separate the character-length arithmetic from an off-by-one in the bit counter.
- An idle run cut by a single low tick, which shows whether a partial character is discarded or wrongly kept.
- A second strobe part-way through, which tests restart against continuation.
- A long idle run after a timeout and another with a zero limit, which separate re-arming from proper disarming.
- Masked and unmasked timeouts, which tell the pulse path apart from the flag path.

// File: rtl/uart_idle_pkg.sv
// Shared constants and types for the receive idle timeout detector.
// Assumes frame data lengths of 5 to 9 bits, optional parity and 1 or 2 stop bits.
package uart_idle_pkg;
    localparam int MIN_DATA     = 5;
    localparam int MAX_DATA     = 9;
    localparam int DLEN_W       = 4;
    localparam int CNT_W        = 16;
    localparam int MAX_CHAR_LEN = 1 + MAX_DATA + 1 + 2;
    localparam int BIT_CNT_W    = $clog2(MAX_CHAR_LEN + 1);

    typedef struct packed {
        logic [DLEN_W-1:0] data_len;
        logic              parity_en;
        logic              two_stop;
    } frame_cfg_t;
endpackage

// File: rtl/idle_char_len.sv
// Computes the length of one idle character in bit times from the frame format.
// Assumes the data length field may be out of range; it is clamped into MIN_DATA..MAX_DATA.
module idle_char_len
    import uart_idle_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  frame_cfg_t           cfg,
    output logic [BIT_CNT_W-1:0] char_len
);
    logic [DLEN_W-1:0] data_bits;

    // Clamp the data length and add start, parity and stop bits.
    always_comb begin
        if (cfg.data_len < DLEN_W'(MIN_DATA))
            data_bits = DLEN_W'(MIN_DATA);
        else if (cfg.data_len > DLEN_W'(MAX_DATA))
            data_bits = DLEN_W'(MAX_DATA);
        else
            data_bits = cfg.data_len;
        char_len = BIT_CNT_W'(1) + BIT_CNT_W'(data_bits)
                 + BIT_CNT_W'(cfg.parity_en)
                 + (cfg.two_stop ? BIT_CNT_W'(2) : BIT_CNT_W'(1));
    end

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (char_len >= BIT_CNT_W'(MIN_DATA + 2)) && (char_len <= BIT_CNT_W'(MAX_CHAR_LEN))); // R2
endmodule

// File: rtl/idle_bit_timer.sv
// Counts high bit ticks within one idle character and flags each completed character.
// Assumes bit_tick is a one-cycle enable; a low line on a tick restarts the character.
module idle_bit_timer
    import uart_idle_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 armed,
    input  logic                 char_strobe,
    input  logic                 bit_tick,
    input  logic                 rx_line,
    input  logic [BIT_CNT_W-1:0] char_len,
    output logic                 char_done
);
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic                 at_end;

    // Detect the last bit of an idle character.
    always_comb begin
        at_end    = (bit_cnt == char_len - BIT_CNT_W'(1));
        char_done = armed && !char_strobe && bit_tick && rx_line && at_end;
    end

    // Advance, reload or hold the bit position within the idle character.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (char_strobe || !armed)
            bit_cnt <= '0;
        else if (bit_tick) begin
            if (!rx_line || at_end)
                bit_cnt <= '0;
            else
                bit_cnt <= bit_cnt + BIT_CNT_W'(1);
        end
    end

    AST_LOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !rx_line) |=> (bit_cnt == '0)); // R5
    AST_STROBE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |=> (bit_cnt == '0)); // R6
endmodule

// File: rtl/idle_char_counter.sv
// Down-counts idle characters after each received character and fires on expiry.
// Assumes char_done is only raised while armed and never with char_strobe.
module idle_char_counter
    import uart_idle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_strobe,
    input  logic             char_done,
    input  logic [CNT_W-1:0] max_idle,
    output logic             armed,
    output logic [CNT_W-1:0] idle_cnt,
    output logic             fire
);
    // The final idle character completes.
    always_comb fire = armed && char_done && (idle_cnt == CNT_W'(1));

    // Load on a new character, count down per idle character, disarm on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            idle_cnt <= '0;
        end else if (char_strobe) begin
            armed    <= (max_idle != '0);
            idle_cnt <= max_idle;
        end else if (armed && char_done) begin
            if (idle_cnt == CNT_W'(1)) begin
                armed    <= 1'b0;
                idle_cnt <= '0;
            end else begin
                idle_cnt <= idle_cnt - CNT_W'(1);
            end
        end
    end

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        char_strobe |=> (idle_cnt == $past(max_idle))); // R3
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && char_done && !char_strobe && idle_cnt != CNT_W'(1)) |=> (idle_cnt == $past(idle_cnt) - CNT_W'(1))); // R3
    AST_ZERO_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (char_strobe && max_idle == '0) |=> !armed); // R7
    AST_DISARMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (idle_cnt == '0)); // R8
    AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (idle_cnt != '0)); // R4
endmodule

// File: rtl/idle_irq_flag.sv
// Registers the timeout pulse and keeps a masked, write-one-to-clear interrupt flag.
// Assumes fire is a single-cycle event; a set in the same cycle as a clear wins.
module idle_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic mask_en,
    input  logic clear,
    output logic timeout_pulse,
    output logic irq_flag
);
    // Register the pulse and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_pulse <= 1'b0;
            irq_flag      <= 1'b0;
        end else begin
            timeout_pulse <= fire;
            if (fire && mask_en)
                irq_flag <= 1'b1;
            else if (clear)
                irq_flag <= 1'b0;
        end
    end

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clear) |=> irq_flag); // R9
    AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_en && !irq_flag) |=> !irq_flag); // R10
endmodule

// File: rtl/uart_idle_timeout.sv
// Top level of the receive idle timeout detector.
// Assumes char_strobe marks each received data character and bit_tick marks each bit time.
module uart_idle_timeout
    import uart_idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              char_strobe,
    input  logic [DLEN_W-1:0] data_len,
    input  logic              parity_en,
    input  logic              two_stop,
    input  logic [CNT_W-1:0]  max_idle,
    input  logic              irq_mask_en,
    input  logic              irq_clear,
    output logic              timeout_pulse,
    output logic              irq_flag,
    output logic [CNT_W-1:0]  idle_count
);
    frame_cfg_t           cfg;
    logic [BIT_CNT_W-1:0] char_len;
    logic                 armed;
    logic                 char_done;
    logic                 fire;

    // Gather the frame fields into one record.
    always_comb cfg = '{data_len: data_len, parity_en: parity_en, two_stop: two_stop};

    idle_char_len u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .char_len (char_len)
    );

    idle_bit_timer u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (armed),
        .char_strobe (char_strobe),
        .bit_tick    (bit_tick),
        .rx_line     (rx_line),
        .char_len    (char_len),
        .char_done   (char_done)
    );

    idle_char_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_strobe (char_strobe),
        .char_done   (char_done),
        .max_idle    (max_idle),
        .armed       (armed),
        .idle_cnt    (idle_count),
        .fire        (fire)
    );

    idle_irq_flag u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (fire),
        .mask_en       (irq_mask_en),
        .clear         (irq_clear),
        .timeout_pulse (timeout_pulse),
        .irq_flag      (irq_flag)
    );

    AST_TIMEOUT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (idle_count == '0)); // R8
endmodule

// File: tb/sim_uart_idle_timeout.sv
`timescale 1ns/1ps
module sim_uart_idle_timeout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        rx_line = 1'b1;
    logic        char_strobe = 1'b0;
    logic [3:0]  data_len = 4'd8;
    logic        parity_en = 1'b0;
    logic        two_stop = 1'b0;
    logic [15:0] max_idle = 16'd0;
    logic        irq_mask_en = 1'b1;
    logic        irq_clear = 1'b0;
    logic        timeout_pulse;
    logic        irq_flag;
    logic [15:0] idle_count;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    exp_q[$];
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_idle_timeout u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
        .char_strobe(char_strobe), .data_len(data_len), .parity_en(parity_en),
        .two_stop(two_stop), .max_idle(max_idle), .irq_mask_en(irq_mask_en),
        .irq_clear(irq_clear), .timeout_pulse(timeout_pulse), .irq_flag(irq_flag),
        .idle_count(idle_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pop the expected timeout cycle and compare as pulses appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (timeout_pulse) begin
                if (exp_q.size() == 0)
                    check(cur_req, cyc, -1);
                else
                    check(cur_req, cyc, exp_q.pop_front());
            end else if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                check(cur_req, -1, exp_q.pop_front());
            end
        end
    end

    // Driver: n bit times at a level; optionally expect a timeout on the last tick.
    task automatic send_bits(input int n, input logic lvl, input bit expect_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            rx_line  = lvl;
            if (expect_last && i == n - 1) exp_q.push_back(cyc + 1);
            @(negedge clk);
            bit_tick = 1'b0;
            rx_line  = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic strobe();
        @(negedge clk);
        char_strobe = 1'b1;
        @(negedge clk);
        char_strobe = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 timeout", timeout_pulse, 0);
        check("R1 irq", irq_flag, 0);
        check("R1 count", idle_count, 0);
        rst_n = 1'b1;

        // 8N1 -> 10-bit characters, limit 2
        cur_req = "R4"; max_idle = 16'd2;
        strobe();
        check("R3 load", idle_count, 2);
        send_bits(10, 1'b1, 0);
        check("R3 decrement", idle_count, 1);
        send_bits(10, 1'b1, 1);
        @(negedge clk);
        check("R8 count zero", idle_count, 0);
        check("R9 irq set", irq_flag, 1);

        // No re-arm without a new character
        cur_req = "R8";
        send_bits(30, 1'b1, 0);
        check("R8 still zero", idle_count, 0);
        check("R9 irq held", irq_flag, 1);
        clear_irq();
        check("R9 irq cleared", irq_flag, 0);

        // Low tick discards a partial idle character
        cur_req = "R5";
        strobe();
        send_bits(7, 1'b1, 0);
        send_bits(1, 1'b0, 0);
        send_bits(9, 1'b1, 0);
        check("R5 no decrement", idle_count, 2);
        send_bits(1, 1'b1, 0);
        check("R5 decrement after full", idle_count, 1);
        send_bits(10, 1'b1, 1);
        clear_irq();

        // New character restarts the count
        cur_req = "R6";
        strobe();
        send_bits(15, 1'b1, 0);
        check("R6 mid count", idle_count, 1);
        strobe();
        check("R6 reload", idle_count, 2);
        send_bits(9, 1'b1, 0);
        check("R6 partial dropped", idle_count, 2);
        send_bits(11, 1'b1, 1);
        clear_irq();

        // Zero limit disables
        cur_req = "R7"; max_idle = 16'd0;
        strobe();
        send_bits(50, 1'b1, 0);
        check("R7 count", idle_count, 0);
        check("R7 irq", irq_flag, 0);

        // 5 data, parity, 2 stop -> 9 bits, limit 3
        cur_req = "R2"; data_len = 4'd5; parity_en = 1'b1; two_stop = 1'b1; max_idle = 16'd3;
        strobe();
        send_bits(26, 1'b1, 0);
        check("R2 9-bit count", idle_count, 1);
        send_bits(1, 1'b1, 1);
        clear_irq();

        // 9 data, parity, 2 stop -> 13 bits, limit 1, interrupt masked
        cur_req = "R10"; data_len = 4'd9; max_idle = 16'd1; irq_mask_en = 1'b0;
        strobe();
        send_bits(12, 1'b1, 0);
        check("R2 13-bit count", idle_count, 1);
        send_bits(1, 1'b1, 1);
        @(negedge clk);
        check("R10 irq masked", irq_flag, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        check("R4 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule